// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher

This block sits between instruction fetch and the eight execution-unit slots of a wide-issue core. It takes in one aligned fetch packet of eight 32-bit instructions at a time. Each instruction's bit 0 is a chaining flag. A run of chained instructions, together with the first unchained one after them, forms one execute packet. The dispatcher sends out one execute packet per handshake. It routes each instruction to the execution unit named inside that instruction, and the slot the instruction occupies in the packet plays no part in that choice.

For every issued instruction the dispatcher also evaluates the optional predicate field against the zero/nonzero state of five condition registers. An instruction whose predicate is false still goes to its unit, but with its write-enable cleared, so it acts as a no-op. The fetch side sees a valid/ready interface. `fp_ready` stays low from the cycle a fetch packet is accepted until its last execute packet has been handed off, and this low level is the stall to fetch. The issue side is also valid/ready. While `ep_ready` is low, the current execute packet stays on the outputs and the issue pointer holds. The hardware does no dependency checking. Two instructions in one execute packet that name the same unit raise a conflict flag.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: After reset `fp_ready` is 1 and `ep_valid` is 0.
- R2: A fetch packet is taken only on a cycle with `fp_valid` and `fp_ready` both high. From the next cycle on, `fp_ready` stays 0 and `ep_valid` stays 1 until the handshake that issues the execute packet containing slot 7.
- R3: An execute packet starts at the first slot not yet issued. It extends through each slot whose bit 0 is 1 and ends at the first slot whose bit 0 is 0. Slot 0 occupies bits 31:0 of `fp_data`, slot 1 bits 63:32, and so on.
- R4: Bit 0 of slot 7 is ignored, so an execute packet never extends past slot 7. After slot 7 issues, `ep_valid` drops and `fp_ready` rises on the next cycle.
- R5: Exactly one execute packet is consumed per cycle with `ep_valid` and `ep_ready` high. While `ep_ready` is 0, `ep_slot_mask`, `unit_valid` and `unit_instr` hold their values.
- R6: The target unit of an instruction is bits 3:1. Bit 3 selects the side, and bits 2:1 select the kind (0 arithmetic/logic, 1 shift/branch, 2 multiply, 3 address). For each instruction in the packet, `unit_valid[u]` is set and `unit_instr[u*32 +: 32]` carries the full instruction. Units that no instruction in the packet targets show `unit_valid` 0.
- R7: The predicate register code is bits 31:29 and the sense bit is bit 28. Code 0 always executes. Codes 1..5 select `cond_nz[0..4]`. With sense 0 the instruction executes when the selected bit is 1, and with sense 1 it executes when that bit is 0. `unit_wen` is 1 exactly when the instruction executes.
- R8: Predicate codes 6 and 7 are reserved. Such an instruction is still routed, but always with `unit_wen` 0.
- R9: `ep_conflict` is 1 when two or more instructions of the current packet name the same unit. The lowest-numbered of those slots then drives that unit.
- R10: `ep_slot_mask` marks with one bit per slot which slots make up the current execute packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Dispatcher can take a fetch packet; low is the stall to fetch |
| fp_data | input | 256 | Eight instructions, slot 0 in the low word |
| cond_nz | input | 5 | Nonzero status of the five condition registers |
| ep_valid | output | 1 | An execute packet is on the issue outputs |
| ep_ready | input | 1 | Execution units accept the packet |
| ep_slot_mask | output | 8 | Slots belonging to the current packet |
| unit_valid | output | 8 | Per-unit instruction present |
| unit_wen | output | 8 | Per-unit write-enable after predicate evaluation |
| unit_instr | output | 256 | Per-unit instruction, unit 0 in the low word |
| ep_conflict | output | 1 | Two instructions in the packet name one unit |

## Verification
The bench runs every one of the 256 chaining-bit patterns through the dispatcher. A design that let slot 7's flag chain, or that misplaced a packet boundary by one slot, would show a wrong mask or leave `ep_valid` high one cycle too long. It also runs every predicate code with both senses against all 32 condition states, which catches inverted sense, mis-indexed registers and reserved codes that write. Stalls on the issue side while a new fetch packet waits expose a pointer that slips under back-pressure or a fetch accepted too early. A packet with two instructions bound to one unit checks the conflict flag and that the lower slot wins.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
  // instruction field positions that this block decodes
  localparam int CHAIN_BIT = 0;
  localparam int UNIT_LSB  = 1;
  localparam int SENSE_BIT = 28;
  localparam int CREG_LSB  = 29;
  localparam int CREG_W    = 3;

  typedef logic [CREG_W-1:0] creg_t;

  // predicate outcome: code 0 always, 1..ncond select a condition bit, rest reserved
  function automatic logic pred_true(input creg_t code, input logic sense,
                                     input logic [7:0] nz_bits, input int ncond);
    logic r;
    if (code == '0) r = 1'b1;
    else if (int'(code) <= ncond) r = nz_bits[int'(code) - 1] ^ sense;
    else r = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/vliw_grp_find.sv
module vliw_grp_find #(
  parameter int SLOTS = 8,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SLOTS-1:0] chain,
  input  logic [PW-1:0]    start,
  output logic [SLOTS-1:0] mask,
  output logic [PW-1:0]    last_idx,
  output logic             closes
);
  logic stop;

  always_comb begin
    mask     = '0;
    last_idx = '0;
    stop     = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i >= int'(start) && !stop) begin
        mask[i]  = 1'b1;
        last_idx = PW'(i);
        if (!chain[i] || i == SLOTS - 1) stop = 1'b1;
      end
    end
  end

  assign closes = mask[SLOTS-1];

  logic [SLOTS-1:0] shifted;
  assign shifted = mask >> start;

  // R3: the group is one contiguous run that begins at the start slot
  a_r3_contiguous_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (shifted[0] && ((shifted & (shifted + 1'b1)) == '0)));
endmodule

// File: rtl/vliw_pred_eval.sv
module vliw_pred_eval
  import vliw_disp_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int NCOND = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS*IW-1:0] instr,
  input  logic [NCOND-1:0]    cond_nz,
  output logic [SLOTS-1:0]    exec_en
);
  logic [7:0] nz_pad;
  assign nz_pad = 8'(cond_nz);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    creg_t code;
    logic  sense;
    assign code  = instr[s*IW + CREG_LSB +: CREG_W];
    assign sense = instr[s*IW + SENSE_BIT];
    assign exec_en[s] = pred_true(code, sense, nz_pad, NCOND);

    // R8: reserved predicate codes never enable a write
    a_r8_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(code) > NCOND) |-> !exec_en[s]);
  end
endmodule

// File: rtl/vliw_unit_router.sv
module vliw_unit_router
  import vliw_disp_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int UNITS = 8,
  localparam int UW = $clog2(UNITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS*IW-1:0] instr,
  input  logic [SLOTS-1:0]    sel,
  input  logic [SLOTS-1:0]    exec_en,
  output logic [UNITS-1:0]    u_valid,
  output logic [UNITS-1:0]    u_wen,
  output logic [UNITS*IW-1:0] u_instr,
  output logic                clash
);
  logic [UW-1:0] tgt [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_tgt
    assign tgt[s] = instr[s*IW + UNIT_LSB +: UW];
  end

  always_comb begin
    u_valid = '0;
    u_wen   = '0;
    u_instr = '0;
    clash   = 1'b0;
    for (int u = 0; u < UNITS; u++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (sel[s] && int'(tgt[s]) == u) begin
          if (u_valid[u]) begin
            clash = 1'b1;
          end else begin
            u_valid[u]           = 1'b1;
            u_wen[u]             = exec_en[s];
            u_instr[u*IW +: IW]  = instr[s*IW +: IW];
          end
        end
      end
    end
  end

  // R6: never more units driven than slots selected
  a_r6_units_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(u_valid) <= $countones(sel));
  // R6: a write-enable only ever accompanies a present instruction
  a_r6_wen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (u_wen & ~u_valid) == '0);
endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int UNITS = 8,
  parameter int NCOND = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fp_valid,
  output logic                fp_ready,
  input  logic [SLOTS*IW-1:0] fp_data,
  input  logic [NCOND-1:0]    cond_nz,
  output logic                ep_valid,
  input  logic                ep_ready,
  output logic [SLOTS-1:0]    ep_slot_mask,
  output logic [UNITS-1:0]    unit_valid,
  output logic [UNITS-1:0]    unit_wen,
  output logic [UNITS*IW-1:0] unit_instr,
  output logic                ep_conflict
);
  localparam int PW = $clog2(SLOTS);

  logic                held;
  logic [PW-1:0]       cursor;
  logic [SLOTS*IW-1:0] pkt_q;
  logic [SLOTS-1:0]    chain;
  logic [SLOTS-1:0]    grp_mask;
  logic [PW-1:0]       grp_end;
  logic                grp_closes;
  logic [SLOTS-1:0]    en_slot;
  logic                take, issue;

  for (genvar s = 0; s < SLOTS; s++) begin : g_chain
    assign chain[s] = pkt_q[s*IW];
  end

  assign fp_ready = !held;
  assign ep_valid = held;
  assign take     = fp_valid && fp_ready;
  assign issue    = held && ep_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      cursor <= '0;
      pkt_q  <= '0;
    end else if (take) begin
      held   <= 1'b1;
      cursor <= '0;
      pkt_q  <= fp_data;
    end else if (issue) begin
      if (grp_closes) held <= 1'b0;
      else cursor <= grp_end + 1'b1;
    end
  end

  vliw_grp_find #(.SLOTS(SLOTS)) u_grp (
    .clk(clk), .rst_n(rst_n), .active(held),
    .chain(chain), .start(cursor),
    .mask(grp_mask), .last_idx(grp_end), .closes(grp_closes)
  );

  vliw_pred_eval #(.SLOTS(SLOTS), .IW(IW), .NCOND(NCOND)) u_pred (
    .clk(clk), .rst_n(rst_n), .instr(pkt_q), .cond_nz(cond_nz), .exec_en(en_slot)
  );

  logic [SLOTS-1:0] sel;
  assign sel = held ? grp_mask : '0;

  vliw_unit_router #(.SLOTS(SLOTS), .IW(IW), .UNITS(UNITS)) u_route (
    .clk(clk), .rst_n(rst_n), .instr(pkt_q), .sel(sel), .exec_en(en_slot),
    .u_valid(unit_valid), .u_wen(unit_wen), .u_instr(unit_instr), .clash(ep_conflict)
  );

  assign ep_slot_mask = sel;

  // R5: a stalled packet stays put on the issue side
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && !ep_ready) |=> (ep_valid && $stable(ep_slot_mask)
                                 && $stable(unit_valid) && $stable(unit_instr)));
  // R2: a packet that does not reach slot 7 leaves more to issue and keeps fetch stalled
  a_r2_keep_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && ep_ready && !ep_slot_mask[SLOTS-1]) |=> (ep_valid && !fp_ready));
  // R4: issuing slot 7 finishes the fetch packet
  a_r4_release_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && ep_ready && ep_slot_mask[SLOTS-1]) |=> (!ep_valid && fp_ready));
  // R9: fewer units driven than slots issued means two slots shared a unit
  a_r9_overlap_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && ($countones(unit_valid) != $countones(ep_slot_mask))) |-> ep_conflict);
  // R10: a valid packet always holds at least one slot
  a_r10_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> (ep_slot_mask != '0));
endmodule

// File: tb/vliw_ep_dispatch_bench.sv
`timescale 1ns/1ps
module vliw_ep_dispatch_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fp_valid = 1'b0;
  logic         fp_ready;
  logic [255:0] fp_data = '0;
  logic [4:0]   cond_nz = '0;
  logic         ep_valid;
  logic         ep_ready = 1'b1;
  logic [7:0]   ep_slot_mask;
  logic [7:0]   unit_valid;
  logic [7:0]   unit_wen;
  logic [255:0] unit_instr;
  logic         ep_conflict;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vliw_ep_dispatch u_vliw_ep_dispatch (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_data(fp_data), .cond_nz(cond_nz), .ep_valid(ep_valid), .ep_ready(ep_ready),
    .ep_slot_mask(ep_slot_mask), .unit_valid(unit_valid), .unit_wen(unit_wen),
    .unit_instr(unit_instr), .ep_conflict(ep_conflict)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // instruction: creg[31:29] sense[28] tag[27:4] unit[3:1] chain[0]
  function automatic logic [31:0] mk(input int creg, input int sense, input int tag,
                                     input int unit, input int chain);
    return {3'(creg), 1'(sense), 24'(tag), 3'(unit), 1'(chain)};
  endfunction

  // expected outputs for one execute packet, from R6 to R9
  task automatic expect_units(input logic [255:0] pkt, input logic [7:0] m,
                              input logic [4:0] nz, output logic [7:0] uv,
                              output logic [7:0] uw, output logic [255:0] ui,
                              output logic cf);
    uv = '0; uw = '0; ui = '0; cf = 1'b0;
    for (int s = 0; s < 8; s++) begin
      if (m[s]) begin
        int u = int'(pkt[s*32+1 +: 3]);
        int c = int'(pkt[s*32+29 +: 3]);
        logic z = pkt[s*32+28];
        logic w = (c == 0) ? 1'b1 : (c <= 5) ? (nz[c-1] ^ z) : 1'b0;
        if (uv[u]) cf = 1'b1;
        else begin
          uv[u] = 1'b1; uw[u] = w; ui[u*32 +: 32] = pkt[s*32 +: 32];
        end
      end
    end
  endtask

  // run one fetch packet; stall_cycles > 0 holds ep_ready low on the first packet
  task automatic run_pkt(input logic [255:0] pkt, input logic [4:0] nz,
                         input int stall_cycles);
    int st = 0;
    cond_nz = nz;
    @(negedge clk);
    chk(fp_ready == 1'b1, "R2 ready before offer", 256'(fp_ready), 256'(1));
    fp_valid = 1'b1; fp_data = pkt;
    @(negedge clk);
    fp_valid = 1'b0;
    while (st < 8) begin
      logic [7:0] m = '0;
      logic [7:0] uv, uw;
      logic [255:0] ui;
      logic cf;
      int e = st;
      while (e < 7 && pkt[e*32]) e++;
      for (int k = st; k <= e; k++) m[k] = 1'b1;
      expect_units(pkt, m, nz, uv, uw, ui, cf);
      if (stall_cycles > 0 && st == 0) begin
        ep_ready = 1'b0;
        fp_valid = 1'b1; fp_data = ~pkt;
        for (int c = 0; c < stall_cycles; c++) begin
          @(negedge clk);
          chk(ep_valid == 1'b1, "R5 valid under stall", 256'(ep_valid), 256'(1));
          chk(ep_slot_mask == m, "R5 mask under stall", 256'(ep_slot_mask), 256'(m));
          chk(unit_instr == ui, "R5 instr under stall", unit_instr, ui);
          chk(fp_ready == 1'b0, "R2 no second take", 256'(fp_ready), 256'(0));
        end
        fp_valid = 1'b0;
        ep_ready = 1'b1;
      end
      chk(ep_valid == 1'b1, "R2 valid while held", 256'(ep_valid), 256'(1));
      chk(fp_ready == 1'b0, "R2 stall to fetch", 256'(fp_ready), 256'(0));
      chk(ep_slot_mask == m, "R3 R10 group mask", 256'(ep_slot_mask), 256'(m));
      chk(unit_valid == uv, "R6 unit valid", 256'(unit_valid), 256'(uv));
      chk(unit_instr == ui, "R6 unit instr", unit_instr, ui);
      chk(unit_wen == uw, "R7 R8 unit wen", 256'(unit_wen), 256'(uw));
      chk(ep_conflict == cf, "R9 conflict", 256'(ep_conflict), 256'(cf));
      @(negedge clk);
      st = e + 1;
    end
    chk(ep_valid == 1'b0, "R4 done after slot 7", 256'(ep_valid), 256'(0));
    chk(fp_ready == 1'b1, "R4 fetch released", 256'(fp_ready), 256'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fp_ready == 1'b1, "R1 reset ready", 256'(fp_ready), 256'(1));
    chk(ep_valid == 1'b0, "R1 reset valid", 256'(ep_valid), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(ep_valid == 1'b0, "R1 idle after reset", 256'(ep_valid), 256'(0));

    // R3 R4 R6: every chaining pattern, unit equals slot so no conflicts
    for (int p = 0; p < 256; p++) begin
      logic [255:0] pkt;
      for (int s = 0; s < 8; s++) pkt[s*32 +: 32] = mk(0, 0, p*16 + s, s, p >> s & 1);
      run_pkt(pkt, 5'h0, 0);
    end

    // R7 R8: every predicate code and sense against every condition state
    for (int z = 0; z < 2; z++) begin
      for (int nz = 0; nz < 32; nz++) begin
        logic [255:0] pkt;
        for (int s = 0; s < 8; s++) pkt[s*32 +: 32] = mk(s, z, nz + 64*z, 7 - s, (s % 3 == 0) ? 1 : 0);
        run_pkt(pkt, 5'(nz), 0);
      end
    end

    // R9: slots 0 and 3 both name unit 5 in one fully chained packet
    begin
      logic [255:0] pkt;
      int umap [8] = '{5, 0, 1, 5, 2, 3, 4, 6};
      for (int s = 0; s < 8; s++) pkt[s*32 +: 32] = mk(0, 0, 100 + s, umap[s], 1);
      run_pkt(pkt, 5'h1f, 0);
    end

    // R5 R2: back-pressure on the first group while fetch offers another packet
    for (int p = 0; p < 4; p++) begin
      logic [255:0] pkt;
      logic [7:0] pat [4] = '{8'h00, 8'h0f, 8'h55, 8'hff};
      for (int s = 0; s < 8; s++) pkt[s*32 +: 32] = mk(4, 1, 300 + s, (s + p) % 8, pat[p][s]);
      run_pkt(pkt, 5'h08, 3 + p);
    end

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end
endmodule